// File: doc/BRIEF.md
# ECC Error Status Capture Unit

This block sits beside the error checkers of two ECC-protected memories, one RAM and one flash. Each checker reports, per cycle, a corrected single-bit error strobe and an uncorrectable error strobe. With the strobes come the details of the faulting access: address, master ID, access attributes and data, and for the RAM also the syndrome. The unit turns these reports into four sticky status flags, one for each memory and severity. Each flag is gated by its own report-enable bit. The unit keeps the details of the last accepted event of each memory in a capture bank and drives one interrupt request to the processor.

Software uses a small register port with a write side and a separate read side. It programs the enables, reads the flags and capture banks, and clears flags by writing ones. When several enabled events arrive in the same cycle, only the one with the highest fixed priority is recorded. The others in that cycle are dropped.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset, every readable register (offsets 0 to 7) reads zero and `ecc_irq` is low.
- R2: The status register (offset 1) holds the RAM corrected flag at bit 5, the flash corrected flag at bit 4, the RAM uncorrectable flag at bit 1 and the flash uncorrectable flag at bit 0. All other bits read zero.
- R3: An event whose report-enable bit is 0 sets no flag and changes no capture register.
- R4: An enabled event that is recorded sets its flag at the clock edge that samples it. The flag then stays set until software clears it.
- R5: Writing the status register clears each flag whose bit is written as 1. Bits written as 0 leave their flags unchanged.
- R6: If the hardware sets a flag in the same cycle that software writes 1 to clear it, the flag stays 1.
- R7: `ecc_irq` is high whenever at least one flag is set. It drops only after every flag has been cleared.
- R8: A recorded RAM event stores its address at offset 2, {syndrome, master ID, attributes} right-aligned at offset 3 (attributes in bits 7:0, master ID in bits 11:8, syndrome in bits 19:12) and its data at offset 4.
- R9: A recorded flash event stores its address at offset 5, {master ID, attributes} right-aligned at offset 6 (attributes in bits 7:0, master ID in bits 11:8, no syndrome field) and its data at offset 7.
- R10: Among the enabled events of one cycle, only the highest-priority one is recorded. The order is RAM corrected, then flash corrected, then RAM uncorrectable, then flash uncorrectable. A disabled event does not block a lower one.
- R11: Each recorded event of a memory overwrites that memory's capture bank. The other bank is left untouched.
- R12: The control register (offset 0) stores report enables at the same bit positions as the status flags (5, 4, 1, 0). Its other bits are not stored and read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ram_cor_evt | input | 1 | RAM corrected single-bit error strobe |
| ram_unc_evt | input | 1 | RAM uncorrectable error strobe |
| ram_addr | input | ADDR_W | RAM faulting address |
| ram_synd | input | SYND_W | RAM syndrome |
| ram_mid | input | MID_W | RAM access master ID |
| ram_attr | input | ATTR_W | RAM access attributes |
| ram_data | input | DATA_W | RAM faulting data |
| fls_cor_evt | input | 1 | Flash corrected single-bit error strobe |
| fls_unc_evt | input | 1 | Flash uncorrectable error strobe |
| fls_addr | input | ADDR_W | Flash faulting address |
| fls_mid | input | MID_W | Flash access master ID |
| fls_attr | input | ATTR_W | Flash access attributes |
| fls_data | input | DATA_W | Flash faulting data |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write offset |
| reg_wdata | input | 8 | Register write data |
| reg_raddr | input | 3 | Register read offset |
| reg_rdata | output | REG_DW | Register read data, combinational from `reg_raddr` |
| ecc_irq | output | 1 | ECC interrupt request |

## Verification
Every event strobe and register write takes effect at the single rising edge that samples it. From that edge on, the flags, `ecc_irq` and the capture banks show the new values, while `reg_rdata` follows `reg_raddr` within the same cycle. Reset release inside the block takes two edges, so the bench waits several cycles before it makes any check. The driver holds each stimulus for exactly one sampling edge. It then queues the expected register contents and does not move on until the monitor has compared all of them. The monitor reads one queued offset per falling edge, while all stimulus inputs are idle, so no result ever depends on when the next stimulus arrives.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;

  // Error classes, listed in recording priority (index 0 wins)
  localparam int unsigned NUM_CLASS   = 4;
  localparam int unsigned CLS_RAM_COR = 0;
  localparam int unsigned CLS_FLS_COR = 1;
  localparam int unsigned CLS_RAM_UNC = 2;
  localparam int unsigned CLS_FLS_UNC = 3;

  // Register port geometry
  localparam int unsigned REG_AW = 3;
  localparam int unsigned REG_BW = 8;

  localparam logic [REG_AW-1:0] RA_CTRL     = 3'd0;
  localparam logic [REG_AW-1:0] RA_STAT     = 3'd1;
  localparam logic [REG_AW-1:0] RA_RAM_ADDR = 3'd2;
  localparam logic [REG_AW-1:0] RA_RAM_META = 3'd3;
  localparam logic [REG_AW-1:0] RA_RAM_DATA = 3'd4;
  localparam logic [REG_AW-1:0] RA_FLS_ADDR = 3'd5;
  localparam logic [REG_AW-1:0] RA_FLS_META = 3'd6;
  localparam logic [REG_AW-1:0] RA_FLS_DATA = 3'd7;

  // Bit position of each class inside the 8-bit status/control byte
  function automatic int unsigned class_pos(input int unsigned cls);
    case (cls)
      CLS_RAM_COR: class_pos = 5;
      CLS_FLS_COR: class_pos = 4;
      CLS_RAM_UNC: class_pos = 1;
      default:     class_pos = 0;
    endcase
  endfunction

  function automatic logic [REG_BW-1:0] pack_classes(input logic [NUM_CLASS-1:0] v);
    logic [REG_BW-1:0] r;
    r = '0;
    for (int unsigned c = 0; c < NUM_CLASS; c++) begin
      r[class_pos(c)] = v[c];
    end
    return r;
  endfunction

  function automatic logic [NUM_CLASS-1:0] unpack_classes(input logic [REG_BW-1:0] r);
    logic [NUM_CLASS-1:0] v;
    for (int unsigned c = 0; c < NUM_CLASS; c++) begin
      v[c] = r[class_pos(c)];
    end
    return v;
  endfunction

endpackage

// File: rtl/ecc_rst_sync.sv
module ecc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/ecc_evt_arbiter.sv
module ecc_evt_arbiter #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req,
  input  logic [N-1:0] en,
  output logic [N-1:0] grant
);

  logic [N-1:0] masked;

  assign masked = req & en;

  // Fixed priority: lower index wins, disabled requests never block
  for (genvar i = 0; i < N; i++) begin : g_pri
    if (i == 0) begin : g_top
      assign grant[i] = masked[i];
    end else begin : g_rest
      assign grant[i] = masked[i] & ~(|masked[i-1:0]);
    end
  end

endmodule

// File: rtl/ecc_status_flags.sv
module ecc_status_flags #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags_q
);

  logic [N-1:0] flags_d;
  logic         flags_en;

  always_comb begin
    flags_en = (|set) | (|clr);
    for (int unsigned i = 0; i < N; i++) begin
      // hardware set dominates a simultaneous software clear
      flags_d[i] = set[i] | (flags_q[i] & ~clr[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

endmodule

// File: rtl/ecc_capture_bank.sv
module ecc_capture_bank #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned META_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [META_W-1:0] meta_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic [META_W-1:0] meta_q,
  output logic [DATA_W-1:0] data_q
);

  logic [ADDR_W-1:0] addr_d;
  logic [META_W-1:0] meta_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    addr_d = addr_q;
    meta_d = meta_q;
    data_d = data_q;
    if (cap_en) begin
      addr_d = addr_i;
      meta_d = meta_i;
      data_d = data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      meta_q <= '0;
      data_q <= '0;
    end else if (cap_en) begin
      addr_q <= addr_d;
      meta_q <= meta_d;
      data_q <= data_d;
    end
  end

endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_cap_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned MID_W  = 4,
  parameter int unsigned ATTR_W = 8,
  parameter int unsigned SYND_W = 8,
  parameter int unsigned REG_DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ram_cor_evt,
  input  logic              ram_unc_evt,
  input  logic [ADDR_W-1:0] ram_addr,
  input  logic [SYND_W-1:0] ram_synd,
  input  logic [MID_W-1:0]  ram_mid,
  input  logic [ATTR_W-1:0] ram_attr,
  input  logic [DATA_W-1:0] ram_data,
  input  logic              fls_cor_evt,
  input  logic              fls_unc_evt,
  input  logic [ADDR_W-1:0] fls_addr,
  input  logic [MID_W-1:0]  fls_mid,
  input  logic [ATTR_W-1:0] fls_attr,
  input  logic [DATA_W-1:0] fls_data,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_waddr,
  input  logic [REG_BW-1:0] reg_wdata,
  input  logic [REG_AW-1:0] reg_raddr,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              ecc_irq
);

  localparam int unsigned RAM_META_W = SYND_W + MID_W + ATTR_W;
  localparam int unsigned FLS_META_W = MID_W + ATTR_W;

  logic                  srst_n;
  logic [NUM_CLASS-1:0]  ctrl_q;
  logic [NUM_CLASS-1:0]  ctrl_d;
  logic                  ctrl_en;
  logic                  stat_wr;
  logic [NUM_CLASS-1:0]  stat_clr;
  logic [NUM_CLASS-1:0]  evt_req;
  logic [NUM_CLASS-1:0]  grant;
  logic [NUM_CLASS-1:0]  flags_q;
  logic                  ram_cap_en;
  logic                  fls_cap_en;
  logic [ADDR_W-1:0]     ram_addr_q;
  logic [RAM_META_W-1:0] ram_meta_q;
  logic [DATA_W-1:0]     ram_data_q;
  logic [ADDR_W-1:0]     fls_addr_q;
  logic [FLS_META_W-1:0] fls_meta_q;
  logic [DATA_W-1:0]     fls_data_q;

  ecc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  // Control register: report enables
  always_comb begin
    ctrl_en = reg_we && (reg_waddr == RA_CTRL);
    ctrl_d  = ctrl_en ? unpack_classes(reg_wdata) : ctrl_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  // Status write-one-to-clear decode
  always_comb begin
    stat_wr  = reg_we && (reg_waddr == RA_STAT);
    stat_clr = stat_wr ? unpack_classes(reg_wdata) : '0;
  end

  always_comb begin
    evt_req                = '0;
    evt_req[CLS_RAM_COR]   = ram_cor_evt;
    evt_req[CLS_FLS_COR]   = fls_cor_evt;
    evt_req[CLS_RAM_UNC]   = ram_unc_evt;
    evt_req[CLS_FLS_UNC]   = fls_unc_evt;
  end

  ecc_evt_arbiter #(.N(NUM_CLASS)) u_arb (
    .req   (evt_req),
    .en    (ctrl_q),
    .grant (grant)
  );

  ecc_status_flags #(.N(NUM_CLASS)) u_flags (
    .clk     (clk),
    .rst_n   (srst_n),
    .set     (grant),
    .clr     (stat_clr),
    .flags_q (flags_q)
  );

  assign ram_cap_en = grant[CLS_RAM_COR] | grant[CLS_RAM_UNC];
  assign fls_cap_en = grant[CLS_FLS_COR] | grant[CLS_FLS_UNC];

  ecc_capture_bank #(
    .ADDR_W (ADDR_W),
    .META_W (RAM_META_W),
    .DATA_W (DATA_W)
  ) u_ram_bank (
    .clk    (clk),
    .rst_n  (srst_n),
    .cap_en (ram_cap_en),
    .addr_i (ram_addr),
    .meta_i ({ram_synd, ram_mid, ram_attr}),
    .data_i (ram_data),
    .addr_q (ram_addr_q),
    .meta_q (ram_meta_q),
    .data_q (ram_data_q)
  );

  ecc_capture_bank #(
    .ADDR_W (ADDR_W),
    .META_W (FLS_META_W),
    .DATA_W (DATA_W)
  ) u_fls_bank (
    .clk    (clk),
    .rst_n  (srst_n),
    .cap_en (fls_cap_en),
    .addr_i (fls_addr),
    .meta_i ({fls_mid, fls_attr}),
    .data_i (fls_data),
    .addr_q (fls_addr_q),
    .meta_q (fls_meta_q),
    .data_q (fls_data_q)
  );

  assign ecc_irq = |flags_q;

  // Read multiplexer
  always_comb begin
    case (reg_raddr)
      RA_CTRL:     reg_rdata = REG_DW'(pack_classes(ctrl_q));
      RA_STAT:     reg_rdata = REG_DW'(pack_classes(flags_q));
      RA_RAM_ADDR: reg_rdata = REG_DW'(ram_addr_q);
      RA_RAM_META: reg_rdata = REG_DW'(ram_meta_q);
      RA_RAM_DATA: reg_rdata = REG_DW'(ram_data_q);
      RA_FLS_ADDR: reg_rdata = REG_DW'(fls_addr_q);
      RA_FLS_META: reg_rdata = REG_DW'(fls_meta_q);
      default:     reg_rdata = REG_DW'(fls_data_q);
    endcase
  end

endmodule

// File: rtl/ecc_err_capture_chk.sv
module ecc_err_capture_chk #(
  parameter int unsigned N      = 4,
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      en,
  input logic [N-1:0]      grant,
  input logic [N-1:0]      flags,
  input logic [N-1:0]      clr,
  input logic              irq,
  input logic              ram_cap_en,
  input logic [ADDR_W-1:0] ram_addr_q,
  input logic              fls_cap_en,
  input logic [ADDR_W-1:0] fls_addr_q
);

  // R10
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R3
  disabled_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~en) == '0);

  // R6
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |=> ((flags & $past(grant)) == $past(grant)));

  // R5
  clear_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |=> ((flags & $past(clr & ~grant)) == '0));

  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags != '0) |=> ((flags & $past(flags & ~clr)) == $past(flags & ~clr)));

  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(grant != '0));

  // R7
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(clr != '0));

  // R11
  ram_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_cap_en |=> $stable(ram_addr_q));

  // R11
  fls_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fls_cap_en |=> $stable(fls_addr_q));

endmodule

bind ecc_err_capture ecc_err_capture_chk #(
  .N      (ecc_cap_pkg::NUM_CLASS),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (srst_n),
  .en         (ctrl_q),
  .grant      (grant),
  .flags      (flags_q),
  .clr        (stat_clr),
  .irq        (ecc_irq),
  .ram_cap_en (ram_cap_en),
  .ram_addr_q (ram_addr_q),
  .fls_cap_en (fls_cap_en),
  .fls_addr_q (fls_addr_q)
);

// File: tb/tb_ecc_err_capture.sv
`timescale 1ns/1ps
module tb_ecc_err_capture;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ram_cor_evt, ram_unc_evt, fls_cor_evt, fls_unc_evt;
  logic [31:0] ram_addr, ram_data, fls_addr, fls_data;
  logic [7:0]  ram_synd, ram_attr, fls_attr;
  logic [3:0]  ram_mid, fls_mid;
  logic        reg_we;
  logic [2:0]  reg_waddr, reg_raddr;
  logic [7:0]  reg_wdata;
  logic [31:0] reg_rdata;
  logic        ecc_irq;

  always #2 clk = ~clk;

  ecc_err_capture dut (
    .clk(clk), .rst_n(rst_n),
    .ram_cor_evt(ram_cor_evt), .ram_unc_evt(ram_unc_evt),
    .ram_addr(ram_addr), .ram_synd(ram_synd), .ram_mid(ram_mid),
    .ram_attr(ram_attr), .ram_data(ram_data),
    .fls_cor_evt(fls_cor_evt), .fls_unc_evt(fls_unc_evt),
    .fls_addr(fls_addr), .fls_mid(fls_mid), .fls_attr(fls_attr),
    .fls_data(fls_data),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .ecc_irq(ecc_irq)
  );

  typedef struct {
    logic [2:0]  a;
    logic [31:0] d;
    logic        irq;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   pending = 0;
  int   n_chk   = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;

  // Monitor: one queued read per falling edge, inputs are idle then
  initial begin
    reg_raddr = 3'd0;
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        reg_raddr = it.a;
        #1;
        n_chk++;
        if (reg_rdata !== it.d || ecc_irq !== it.irq) begin
          n_fail++;
          $display("FAIL %s: offset %0d actual data=%h irq=%b expected data=%h irq=%b",
                   it.tag, it.a, reg_rdata, ecc_irq, it.d, it.irq);
        end
        pending--;
      end
    end
  end

  task automatic chk(input logic [2:0] a, input logic [31:0] d, input logic irq,
                     input string tag);
    exp_t it;
    it.a = a; it.d = d; it.irq = irq; it.tag = tag;
    pending++;
    sb_q.push_back(it);
  endtask

  task automatic flush();
    wait (pending == 0);
  endtask

  // One sampling edge of stimulus; ev = {fls_unc, ram_unc, fls_cor, ram_cor}
  task automatic cycle(input logic [3:0] ev, input logic we,
                       input logic [2:0] wa, input logic [7:0] wd);
    @(posedge clk); #1;
    {fls_unc_evt, ram_unc_evt, fls_cor_evt, ram_cor_evt} = ev;
    reg_we = we; reg_waddr = wa; reg_wdata = wd;
    @(posedge clk); #1;
    {fls_unc_evt, ram_unc_evt, fls_cor_evt, ram_cor_evt} = 4'b0;
    reg_we = 1'b0;
  endtask

  task automatic wr(input logic [2:0] wa, input logic [7:0] wd);
    cycle(4'b0, 1'b1, wa, wd);
  endtask

  task automatic ev(input logic [3:0] e);
    cycle(e, 1'b0, 3'd0, 8'h00);
  endtask

  task automatic set_ram(input logic [31:0] a, input logic [7:0] s,
                         input logic [3:0] m, input logic [7:0] t, input logic [31:0] d);
    ram_addr = a; ram_synd = s; ram_mid = m; ram_attr = t; ram_data = d;
  endtask

  task automatic set_fls(input logic [31:0] a, input logic [3:0] m,
                         input logic [7:0] t, input logic [31:0] d);
    fls_addr = a; fls_mid = m; fls_attr = t; fls_data = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {fls_unc_evt, ram_unc_evt, fls_cor_evt, ram_cor_evt} = 4'b0;
    reg_we = 1'b0; reg_waddr = 3'd0; reg_wdata = 8'h00;
    set_ram(32'h0, 8'h0, 4'h0, 8'h0, 32'h0);
    set_fls(32'h0, 4'h0, 8'h0, 32'h0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R1: everything zero after reset
    for (int a = 0; a < 8; a++) chk(3'(a), 32'h0, 1'b0, "R1");
    flush();

    // R3: enables are zero, events are ignored
    set_ram(32'h100, 8'h11, 4'h1, 8'h02, 32'h11110000);
    ev(4'b0101);
    chk(3'd1, 32'h0, 1'b0, "R3");
    chk(3'd2, 32'h0, 1'b0, "R3");
    flush();

    // R12: only enable bits are stored
    wr(3'd0, 8'hFF);
    chk(3'd0, 32'h33, 1'b0, "R12");
    flush();

    // R2 R4 R8: RAM corrected event
    set_ram(32'h1000, 8'h5A, 4'h3, 8'h21, 32'hDEADBEEF);
    ev(4'b0001);
    chk(3'd1, 32'h20, 1'b1, "R2");
    chk(3'd2, 32'h1000, 1'b1, "R8");
    chk(3'd3, 32'h5A321, 1'b1, "R8");
    chk(3'd4, 32'hDEADBEEF, 1'b1, "R8");
    flush();

    // R9 R11: flash uncorrectable event, RAM bank untouched
    set_fls(32'h2000, 4'h7, 8'h44, 32'hCAFE0001);
    ev(4'b1000);
    chk(3'd1, 32'h21, 1'b1, "R4");
    chk(3'd5, 32'h2000, 1'b1, "R9");
    chk(3'd6, 32'h744, 1'b1, "R9");
    chk(3'd7, 32'hCAFE0001, 1'b1, "R9");
    chk(3'd2, 32'h1000, 1'b1, "R11");
    flush();

    // R5 R7: write-one-to-clear
    wr(3'd1, 8'h00);
    chk(3'd1, 32'h21, 1'b1, "R5");
    flush();
    wr(3'd1, 8'hDE);
    chk(3'd1, 32'h21, 1'b1, "R5");
    flush();
    wr(3'd1, 8'h20);
    chk(3'd1, 32'h01, 1'b1, "R7");
    flush();
    wr(3'd1, 8'h01);
    chk(3'd1, 32'h00, 1'b0, "R7");
    flush();

    // R10: all four at once, RAM corrected wins
    set_ram(32'h3000, 8'h0F, 4'h2, 8'h10, 32'h33333333);
    set_fls(32'h4000, 4'h5, 8'h55, 32'h44444444);
    ev(4'b1111);
    chk(3'd1, 32'h20, 1'b1, "R10");
    chk(3'd2, 32'h3000, 1'b1, "R10");
    chk(3'd5, 32'h2000, 1'b1, "R10");
    flush();
    wr(3'd1, 8'hFF);

    // R10: flash corrected beats RAM uncorrectable
    set_ram(32'h3100, 8'h0F, 4'h2, 8'h10, 32'h33333333);
    ev(4'b0110);
    chk(3'd1, 32'h10, 1'b1, "R10");
    chk(3'd5, 32'h4000, 1'b1, "R10");
    chk(3'd2, 32'h3000, 1'b1, "R10");
    flush();
    wr(3'd1, 8'hFF);

    // R10: RAM uncorrectable beats flash uncorrectable
    set_fls(32'h4100, 4'h5, 8'h55, 32'h44444444);
    ev(4'b1100);
    chk(3'd1, 32'h02, 1'b1, "R10");
    chk(3'd2, 32'h3100, 1'b1, "R10");
    chk(3'd5, 32'h4000, 1'b1, "R10");
    flush();
    wr(3'd1, 8'hFF);

    // R3 R10: disabled RAM corrected does not block flash corrected
    wr(3'd0, 8'h13);
    ev(4'b1111);
    chk(3'd1, 32'h10, 1'b1, "R3");
    chk(3'd5, 32'h4100, 1'b1, "R10");
    flush();
    wr(3'd1, 8'hFF);
    wr(3'd0, 8'h33);

    // R6 R11: set beats clear, capture overwritten
    set_ram(32'h5000, 8'h01, 4'h1, 8'h01, 32'h55555555);
    ev(4'b0100);
    chk(3'd1, 32'h02, 1'b1, "R6");
    flush();
    set_ram(32'h6000, 8'h02, 4'h2, 8'h02, 32'h66666666);
    cycle(4'b0100, 1'b1, 3'd1, 8'h02);
    chk(3'd1, 32'h02, 1'b1, "R6");
    chk(3'd2, 32'h6000, 1'b1, "R11");
    chk(3'd4, 32'h66666666, 1'b1, "R11");
    flush();
    wr(3'd1, 8'h02);
    chk(3'd1, 32'h00, 1'b0, "R5");
    flush();

    // R3: all disabled again, capture untouched
    wr(3'd0, 8'h00);
    set_ram(32'h7000, 8'h03, 4'h3, 8'h03, 32'h77777777);
    ev(4'b0101);
    chk(3'd2, 32'h6000, 1'b0, "R3");
    chk(3'd1, 32'h00, 1'b0, "R3");
    flush();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule